// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers fifteen interrupt request lines (numbered 1 to 15) for one processor and reports the most urgent one as a 4-bit interrupt number. Software programs it over a simple 32-bit read/write strobe bus. Each line may be marked as urgent (level 1) or normal (level 0). Requests come from two sources. The hardware lines latch into a pending set. Software can also force a line on directly, and a per-line broadcast bit steers a hardware request into the forced set instead of the pending set.

The set of active lines is the union of pending and forced lines, filtered by an enable mask. Urgent active lines always beat normal ones. Within the winning group the highest line number is reported. An output of 0 means that nothing is active. When the processor services an interrupt, it returns the number on an acknowledge port, and that line is removed from both the pending and the forced set.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq_id` is 0.
- R2: Bit 0 is unusable. It is dropped from writes to the level (0x00), force (0x08, 0x80), clear (0x0C), broadcast (0x14) and mask (0x40) registers, and request line 0 never sets anything.
- R3: A line is active when it is pending or forced and its bit in the mask register (0x40) is 1. `irq_id` is 0 when no line is active.
- R4: When any active line has its level bit (0x00) set to 1, `irq_id` reports the highest-numbered such line. Otherwise it reports the highest-numbered active line.
- R5: On a rising request on line n, the block sets force bit n when broadcast bit n is 1, and sets pending bit n (read at 0x04) otherwise.
- R6: Requests are edge detected on the clock. An input held high sets its pending bit only once, so a bit that has been cleared stays clear while the input remains high.
- R7: Writing the clear register (0x0C) clears each pending bit written as 1. The clear register and the status register (0x10) always read 0.
- R8: The pending register is read-only, and a write to 0x04 changes nothing.
- R9: A write to the force register at 0x80 computes force = (force | wdata[15:1]) & ~wdata[31:17]. The upper half is the clear mask for the same line numbers.
- R10: A write to 0x08 replaces the force register with wdata[15:1].
- R11: An acknowledge with number n clears pending bit n and force bit n, and `irq_id` is re-evaluated on the next cycle.
- R12: When a rising request on line n lands in the same cycle as a clear or acknowledge of bit n, the bit ends up set.
- R13: Reads return level at 0x00, pending at 0x04, force at both 0x08 and 0x80, broadcast at 0x14 and mask at 0x40. Every other address reads 0. All register changes become visible the cycle after the clock edge that takes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Interrupt request lines; bit 0 is unused |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is 0 when low |
| addr | input | 8 | Word-aligned byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 4 | Number of the interrupt being acknowledged |
| irq_id | output | 4 | Highest-priority active interrupt, 0 for none |

## Verification
The bench places a low-numbered urgent line against a high-numbered normal line. A resolver that ignores levels would report 9 instead of 3. It also writes the clear register while a request input stays high; a level-sensitive latch would re-set the pending bit at once. Same-cycle collisions are covered: a fresh edge arriving together with a clear or an acknowledge of the same bit must leave the bit set, and a design with the wrong ordering would drop the request. The set and clear halves of the force register, bit-0 stripping, and broadcast steering are each checked through readback. A swapped half, a leaked bit 0 or a request sent to the wrong set therefore shows up in the read data.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_LEVEL  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_PEND   = 8'h04;
  localparam logic [REG_AW-1:0] OFS_FALIAS = 8'h08;
  localparam logic [REG_AW-1:0] OFS_CLEAR  = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_STAT   = 8'h10;
  localparam logic [REG_AW-1:0] OFS_BCAST  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_MASK   = 8'h40;
  localparam logic [REG_AW-1:0] OFS_FSC    = 8'h80;

  // One-hot write selects decoded from the bus
  typedef struct packed {
    logic level;
    logic falias;
    logic clear;
    logic bcast;
    logic mask;
    logic frc_sc;
  } wr_sel_t;

  // Index of the most significant set bit, 0 when empty
  function automatic logic [4:0] top_index(input logic [31:0] v);
    logic [4:0] idx;
    idx = '0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) idx = 5'(i);
    end
    return idx;
  endfunction

  // Set-then-clear merge for the force register
  function automatic logic [31:0] force_merge(input logic [31:0] old_v,
                                              input logic [31:0] set_v,
                                              input logic [31:0] clr_v);
    return (old_v | set_v) & ~clr_v;
  endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] rise
);
  localparam logic [N-1:0] USE_MASK = {{(N-1){1'b1}}, 1'b0};

  logic [N-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_i;
  end

  assign rise = req_i & ~req_q & USE_MASK;

  // R6
  no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned N      = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_sel_t           sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      rise,
  input  logic [N-1:0]      ack_vec,
  output logic [N-1:0]      level_q,
  output logic [N-1:0]      pend_q,
  output logic [N-1:0]      force_q,
  output logic [N-1:0]      bcast_q,
  output logic [N-1:0]      mask_q
);
  localparam int unsigned HALF = DATA_W / 2;
  localparam logic [N-1:0] USE_MASK = {{(N-1){1'b1}}, 1'b0};

  logic [N-1:0] wd_lo, wd_hi;
  logic [N-1:0] rise_pend, rise_frc;
  logic [N-1:0] pend_drop, pend_d, force_base, force_d;

  assign wd_lo     = wdata[N-1:0] & USE_MASK;
  assign wd_hi     = wdata[HALF +: N] & USE_MASK;
  assign rise_pend = rise & ~bcast_q;
  assign rise_frc  = rise & bcast_q;

  always_comb begin
    logic [31:0] merged;
    merged     = force_merge(32'(force_q), 32'(wd_lo), 32'(wd_hi));
    pend_drop  = (sel.clear ? wd_lo : '0) | ack_vec;
    pend_d     = (pend_q & ~pend_drop) | rise_pend;
    if (sel.falias)      force_base = wd_lo;
    else if (sel.frc_sc) force_base = merged[N-1:0];
    else                 force_base = force_q;
    force_d    = (force_base & ~ack_vec) | rise_frc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      pend_q  <= '0;
      force_q <= '0;
      bcast_q <= '0;
      mask_q  <= '0;
    end else begin
      pend_q  <= pend_d;
      force_q <= force_d;
      if (sel.level) level_q <= wd_lo;
      if (sel.bcast) bcast_q <= wd_lo;
      if (sel.mask)  mask_q  <= wd_lo;
    end
  end

  // R2
  bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(level_q[0] | pend_q[0] | force_q[0] | bcast_q[0] | mask_q[0]));

  // R5, R12
  rise_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> (((pend_q | force_q) & $past(rise)) == $past(rise)));

  // R11
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_vec) |=> (((pend_q | force_q) & $past(ack_vec & ~rise)) == '0));

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
  import irq_prio_pkg::*;
#(
  parameter int unsigned N    = 16,
  parameter int unsigned ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pend_q,
  input  logic [N-1:0]    force_q,
  input  logic [N-1:0]    mask_q,
  input  logic [N-1:0]    level_q,
  output logic [ID_W-1:0] irq_id
);
  logic [N-1:0] active, hi_set, lo_set, win_set;
  logic [4:0]   win_idx;

  assign active  = (pend_q | force_q) & mask_q;
  assign hi_set  = active & level_q;
  assign lo_set  = active & ~level_q;
  assign win_set = (|hi_set) ? hi_set : lo_set;
  assign win_idx = top_index(32'(win_set));
  assign irq_id  = win_idx[ID_W-1:0];

  // R3
  idle_means_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_id != '0) == (|active)));

  // R4
  level_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hi_set) |-> (level_q[irq_id] && active[irq_id]));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned N      = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       req_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [REG_AW-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               ack_valid,
  input  logic [$clog2(N)-1:0] ack_id,
  output logic [$clog2(N)-1:0] irq_id
);
  localparam int unsigned ID_W = $clog2(N);
  localparam logic [N-1:0] USE_MASK = {{(N-1){1'b1}}, 1'b0};

  wr_sel_t      sel;
  logic [N-1:0] rise, ack_vec;
  logic [N-1:0] level_q, pend_q, force_q, bcast_q, mask_q;

  always_comb begin
    sel        = '0;
    sel.level  = wr_en && (addr == OFS_LEVEL);
    sel.falias = wr_en && (addr == OFS_FALIAS);
    sel.clear  = wr_en && (addr == OFS_CLEAR);
    sel.bcast  = wr_en && (addr == OFS_BCAST);
    sel.mask   = wr_en && (addr == OFS_MASK);
    sel.frc_sc = wr_en && (addr == OFS_FSC);
  end

  assign ack_vec = ack_valid ? (({{(N-1){1'b0}}, 1'b1} << ack_id) & USE_MASK) : '0;

  irq_edge_det #(.N(N)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .rise  (rise)
  );

  irq_state_regs #(.N(N), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .wdata   (wdata),
    .rise    (rise),
    .ack_vec (ack_vec),
    .level_q (level_q),
    .pend_q  (pend_q),
    .force_q (force_q),
    .bcast_q (bcast_q),
    .mask_q  (mask_q)
  );

  irq_prio_resolve #(.N(N), .ID_W(ID_W)) u_resolve (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_q  (pend_q),
    .force_q (force_q),
    .mask_q  (mask_q),
    .level_q (level_q),
    .irq_id  (irq_id)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_LEVEL:          rdata = DATA_W'(level_q);
        OFS_PEND:           rdata = DATA_W'(pend_q);
        OFS_FALIAS, OFS_FSC: rdata = DATA_W'(force_q);
        OFS_BCAST:          rdata = DATA_W'(bcast_q);
        OFS_MASK:           rdata = DATA_W'(mask_q);
        default:            rdata = '0;
      endcase
    end
  end

  // R8
  pend_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_PEND && rise == '0 && ack_vec == '0) |=> (pend_q == $past(pend_q)));

  // R7
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == OFS_CLEAR || addr == OFS_STAT)) |-> (rdata == '0));

endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_i = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_id = '0;
  logic [3:0]  irq_id;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    bit          is_rd;
    logic [31:0] exp;
  } exp_t;
  exp_t sb_q[$];

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ack_valid(ack_valid),
    .ack_id(ack_id), .irq_id(irq_id)
  );

  always #10 clk = ~clk;

  // Monitor: pops expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      logic [31:0] got;
      e = sb_q.pop_front();
      got = e.is_rd ? rdata : {28'd0, irq_id};
      checks++;
      if (got !== e.exp) begin
        errors++;
        $display("FAIL %s: got 0x%0h expected 0x%0h", e.tag, got, e.exp);
      end
    end
  end

  task automatic idle();
    @(posedge clk); #2;
  endtask

  task automatic exp_irq(string tag, int v);
    sb_q.push_back('{tag: tag, is_rd: 1'b0, exp: 32'(v)});
    idle();
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    idle();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    addr = a; rd_en = 1'b1;
    sb_q.push_back('{tag: tag, is_rd: 1'b1, exp: exp});
    idle();
    rd_en = 1'b0;
  endtask

  task automatic ack(logic [3:0] n);
    ack_id = n; ack_valid = 1'b1;
    idle();
    ack_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    exp_irq("R1 irq after reset", 0);
    rd_chk("R1 pending reset", 8'h04, 32'h0);
    rd_chk("R1 force reset", 8'h08, 32'h0);
    rd_chk("R1 level reset", 8'h00, 32'h0);
    // R2 mask bit 0 dropped
    bus_wr(8'h40, 32'h0000_FFFF);
    rd_chk("R2 mask bit0", 8'h40, 32'h0000_FFFE);
    // R5 request to pending
    req_i = 16'h0020; idle();
    exp_irq("R5 irq line5", 5);
    rd_chk("R5 pending line5", 8'h04, 32'h20);
    // R6/R7 clear while held
    bus_wr(8'h0C, 32'h0000_0021);
    idle(); idle(); idle();
    rd_chk("R6 held input no re-set", 8'h04, 32'h0);
    exp_irq("R7 irq after clear", 0);
    rd_chk("R7 clear reads zero", 8'h0C, 32'h0);
    rd_chk("R7 status reads zero", 8'h10, 32'h0);
    // R4 level priority
    req_i = 16'h0000; idle();
    req_i = 16'h0208; idle();
    exp_irq("R4 highest normal", 9);
    bus_wr(8'h00, 32'h0000_0009);
    rd_chk("R2 level bit0", 8'h00, 32'h8);
    exp_irq("R4 urgent beats higher", 3);
    // R3 mask
    bus_wr(8'h40, 32'h0000_FFF6);
    exp_irq("R3 masked urgent", 9);
    bus_wr(8'h40, 32'h0);
    exp_irq("R3 all masked", 0);
    bus_wr(8'h40, 32'h0000_FFFE);
    exp_irq("R3 unmasked", 3);
    // R11 acknowledge
    ack(4'd3);
    rd_chk("R11 pending after ack3", 8'h04, 32'h200);
    exp_irq("R11 irq after ack3", 9);
    ack(4'd9);
    exp_irq("R11 irq after ack9", 0);
    req_i = 16'h0000; idle();
    // R8 pending read-only
    bus_wr(8'h04, 32'h0000_FFFF);
    rd_chk("R8 pending write ignored", 8'h04, 32'h0);
    // R9 force set/clear
    bus_wr(8'h80, 32'h0000_0013);
    rd_chk("R9 force set", 8'h80, 32'h12);
    rd_chk("R13 force alias read", 8'h08, 32'h12);
    exp_irq("R9 irq forced", 4);
    bus_wr(8'h80, 32'h0010_0040);
    rd_chk("R9 force set and clear", 8'h80, 32'h42);
    exp_irq("R9 irq after clear half", 6);
    bus_wr(8'h80, 32'h0001_0000);
    rd_chk("R2 force clear bit0", 8'h80, 32'h42);
    // R10 alias replace
    bus_wr(8'h08, 32'h0000_0009);
    rd_chk("R10 alias replace", 8'h80, 32'h8);
    exp_irq("R10 irq", 3);
    ack(4'd3);
    rd_chk("R11 force cleared by ack", 8'h80, 32'h0);
    exp_irq("R11 irq idle", 0);
    // R5 broadcast steering
    bus_wr(8'h14, 32'h0000_0401);
    rd_chk("R2 bcast bit0", 8'h14, 32'h400);
    req_i = 16'h0400; idle();
    rd_chk("R5 bcast to force", 8'h80, 32'h400);
    rd_chk("R5 bcast not pending", 8'h04, 32'h0);
    exp_irq("R5 bcast irq", 10);
    req_i = 16'h0000;
    ack(4'd10);
    exp_irq("R11 after bcast ack", 0);
    bus_wr(8'h14, 32'h0);
    // R2 line 0
    req_i = 16'h0001; idle();
    rd_chk("R2 line0 pending", 8'h04, 32'h0);
    exp_irq("R2 line0 irq", 0);
    req_i = 16'h0000; idle();
    // R12 collisions
    req_i = 16'h0080; idle();
    req_i = 16'h0000; idle();
    req_i = 16'h0080;
    bus_wr(8'h0C, 32'h0000_0080);
    rd_chk("R12 rise beats clear", 8'h04, 32'h80);
    req_i = 16'h0000; idle();
    req_i = 16'h0080;
    ack(4'd7);
    rd_chk("R12 rise beats ack", 8'h04, 32'h80);
    exp_irq("R12 irq", 7);
    req_i = 16'h0000; idle();
    ack(4'd7);
    rd_chk("R11 pending after ack7", 8'h04, 32'h0);
    // R13 unmapped
    rd_chk("R13 unmapped read", 8'h44, 32'h0);
    idle(); idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule